// File: doc/BRIEF.md
# Printer Port Bus Interface

This block connects a parallel printer to a CPU bus. Software polls the printer's status lines by reading one of two I/O ports, or, when a legacy compatibility mode is selected, one of two memory locations. The status byte goes straight onto the read data bus without a clock delay. A data output enable marks the cycles in which the block drives the bus.

An I/O write to the data port captures the low data byte into a holding register that drives the printer data pins. The same write starts a one-shot that pulls the active-low strobe down for a fixed number of clocks. The default is one microsecond at the default clock rate.

The CPU side uses plain bus strobes with no handshake. Each clock cycle in which the write strobe is high and the port decodes counts as one write. The bus never has to wait, so the block applies no back-pressure. A write during a strobe pulse is accepted at once.

Top module: `prn_port`

## Requirements
- R1: After reset, `prn_data` is 0x00, `prn_strobe_n` is 1 and `cpu_rdata_oe` is 0.
- R2: With `io_rd` high and `cpu_addr[7:0]` equal to 0xF8 or 0xF9, in the same cycle `cpu_rdata_oe` is 1 and `cpu_rdata` equals `prn_status`. The upper address byte is ignored for I/O.
- R3: With `mem_rd` and `compat_mode` high and `cpu_addr` equal to 0x37E8 or 0x37E9, in the same cycle `cpu_rdata_oe` is 1 and `cpu_rdata` equals `prn_status`.
- R4: With `compat_mode` low, a memory read of 0x37E8 or 0x37E9 gives `cpu_rdata_oe` 0.
- R5: In every cycle without a decoded read, `cpu_rdata_oe` is 0 and `cpu_rdata` is 0x00.
- R6: A cycle with `io_wr` high and `cpu_addr[7:0]` equal to 0xF8 loads `cpu_wdata` into `prn_data`, visible from the next cycle. A write to 0xF9 or to any other port leaves `prn_data` unchanged.
- R7: A data write drives `prn_strobe_n` low for exactly `STROBE_CYCLES` cycles, starting in the cycle after the write. It then returns high.
- R8: A data write while the strobe is low restarts the pulse. The strobe stays low for `STROBE_CYCLES` cycles after the latest write, and `prn_data` carries the new byte.
- R9: `prn_data` holds its value in every cycle without a data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | CPU address; bits 7:0 form the I/O port number |
| cpu_wdata | input | 8 | CPU write data |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe, one write per high cycle |
| mem_rd | input | 1 | Memory read strobe |
| compat_mode | input | 1 | Enables the legacy memory-mapped status addresses |
| prn_status | input | 8 | Printer status lines |
| cpu_rdata | output | 8 | Read data bus, 0 when not driven |
| cpu_rdata_oe | output | 1 | Read data output enable |
| prn_data | output | 8 | Latched character to the printer |
| prn_strobe_n | output | 1 | Printer strobe, active low |

## Verification
The only internal state is the data register and the strobe counter, and both are visible at the ports in the cycle after a write. A counter that loads the wrong value, or fails to reload on a restart, changes the strobe width. The bench counts the low cycles, so the error shows at the first pulse end after the fault. A wrong latch enable shows in the next cycle as a changed or stale `prn_data`. Decode faults are combinational and show in the same cycle as the read.

// File: rtl/prn_pkg.sv
package prn_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int PORT_W = 8;
  localparam int N_STAT = 2;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_IO   = 2'd1,
    RD_MEM  = 2'd2
  } rd_src_e;
endpackage

// File: rtl/prn_decode.sv
module prn_decode
  import prn_pkg::*;
#(
  parameter logic [N_STAT-1:0][PORT_W-1:0] IO_STAT  = {8'hF9, 8'hF8},
  parameter logic [N_STAT-1:0][ADDR_W-1:0] MEM_STAT = {16'h37E9, 16'h37E8},
  parameter logic [PORT_W-1:0]             IO_DATA  = 8'hF8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic              mem_rd,
  input  logic              compat,
  output rd_src_e           rd_src,
  output logic              data_wr
);
  logic [N_STAT-1:0] io_hit;
  logic [N_STAT-1:0] mem_hit;

  for (genvar g = 0; g < N_STAT; g++) begin : g_cmp
    assign io_hit[g]  = (addr[PORT_W-1:0] == IO_STAT[g]);
    assign mem_hit[g] = (addr == MEM_STAT[g]);
  end

  always_comb begin
    if (io_rd && |io_hit)                 rd_src = RD_IO;
    else if (mem_rd && compat && |mem_hit) rd_src = RD_MEM;
    else                                   rd_src = RD_NONE;
  end

  assign data_wr = io_wr && (addr[PORT_W-1:0] == IO_DATA);
endmodule

// File: rtl/prn_latch.sv
module prn_latch
  import prn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= din;
  end

  a_r6_load_takes_byte: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> dout == $past(din));
  a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(dout));
endmodule

// File: rtl/prn_strobe.sv
module prn_strobe #(
  parameter int WIDTH = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic strobe_n
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(WIDTH);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (fire)           remain <= LOAD;
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign strobe_n = (remain == '0);

  a_r7_fire_pulls_low: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !strobe_n);
  a_r7_ends_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (remain == 1 && !fire) |=> strobe_n);
  a_r8_idle_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_n && !fire) |=> strobe_n);
endmodule

// File: rtl/prn_port.sv
module prn_port
  import prn_pkg::*;
#(
  parameter int CLK_HZ   = 20_000_000,
  parameter int PULSE_NS = 1000,
  parameter int STROBE_CYCLES = (CLK_HZ / 1_000_000) * PULSE_NS / 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic              mem_rd,
  input  logic              compat_mode,
  input  logic [DATA_W-1:0] prn_status,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rdata_oe,
  output logic [DATA_W-1:0] prn_data,
  output logic              prn_strobe_n
);
  localparam int STROBE_W = (STROBE_CYCLES < 1) ? 1 : STROBE_CYCLES;

  rd_src_e rd_src;
  logic    data_wr;

  prn_decode u_decode (
    .addr    (cpu_addr),
    .io_rd   (io_rd),
    .io_wr   (io_wr),
    .mem_rd  (mem_rd),
    .compat  (compat_mode),
    .rd_src  (rd_src),
    .data_wr (data_wr)
  );

  prn_latch u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (data_wr),
    .din   (cpu_wdata),
    .dout  (prn_data)
  );

  prn_strobe #(.WIDTH(STROBE_W)) u_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (data_wr),
    .strobe_n (prn_strobe_n)
  );

  assign cpu_rdata_oe = (rd_src != RD_NONE);
  assign cpu_rdata    = cpu_rdata_oe ? prn_status : '0;

  a_r2_io_status: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && (cpu_addr[7:0] == 8'hF8 || cpu_addr[7:0] == 8'hF9))
      |-> (cpu_rdata_oe && cpu_rdata == prn_status));
  a_r3_mem_status: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && compat_mode && (cpu_addr == 16'h37E8 || cpu_addr == 16'h37E9))
      |-> (cpu_rdata_oe && cpu_rdata == prn_status));
  a_r4_mem_off_without_compat: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !compat_mode && !io_rd) |-> !cpu_rdata_oe);
  a_r5_quiet_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_rd && !mem_rd) |-> (!cpu_rdata_oe && cpu_rdata == '0));
endmodule

// File: tb/test_prn_port.sv
module test_prn_port;
  localparam int CLK_PERIOD = 10;
  localparam int SC = 20;
  localparam int N_RAND = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0, mem_rd = 1'b0, compat_mode = 1'b0;
  logic [7:0]  prn_status = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_rdata_oe;
  logic [7:0]  prn_data;
  logic        prn_strobe_n;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_data = '0;
  int exp_left = 0;
  bit done = 0;

  prn_port i_prn_port (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .io_rd(io_rd), .io_wr(io_wr), .mem_rd(mem_rd), .compat_mode(compat_mode),
    .prn_status(prn_status), .cpu_rdata(cpu_rdata), .cpu_rdata_oe(cpu_rdata_oe),
    .prn_data(prn_data), .prn_strobe_n(prn_strobe_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit exp_oe(logic [15:0] a, logic ir, logic mr, logic cm);
    return (ir && (a[7:0] == 8'hF8 || a[7:0] == 8'hF9)) ||
           (mr && cm && (a == 16'h37E8 || a == 16'h37E9));
  endfunction

  function automatic bit is_data_wr(logic [15:0] a, logic iw);
    return iw && a[7:0] == 8'hF8;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, check the read path, clock, check registers.
  task automatic cycle(logic [15:0] a, logic [7:0] wd, logic ir, logic iw,
                       logic mr, logic cm, logic [7:0] st, string rtag);
    bit eo;
    cpu_addr = a; cpu_wdata = wd; io_rd = ir; io_wr = iw; mem_rd = mr;
    compat_mode = cm; prn_status = st;
    #1;
    eo = exp_oe(a, ir, mr, cm);
    check(rtag, cpu_rdata_oe, eo);
    check(rtag, cpu_rdata, eo ? st : 8'h00);
    @(posedge clk);
    if (is_data_wr(a, iw)) begin
      exp_data = wd;
      exp_left = SC;
    end else if (exp_left > 0) exp_left--;
    @(negedge clk);
    check("R6/R9 data", prn_data, exp_data);
    check("R7/R8 strobe", prn_strobe_n, exp_left == 0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle(16'h0000, 8'h00, 0, 0, 0, 0, 8'h00, "R5");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    int low_cnt;
    seed = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    check("R1 data", prn_data, 0);
    check("R1 strobe", prn_strobe_n, 1);
    check("R1 oe", cpu_rdata_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: I/O status reads, upper byte ignored
    cycle(16'h00F8, 8'h00, 1, 0, 0, 0, 8'hA5, "R2");
    cycle(16'hABF9, 8'h00, 1, 0, 0, 0, 8'h3C, "R2");
    cycle(16'h00FA, 8'h00, 1, 0, 0, 0, 8'h3C, "R5");
    // R3 / R4: memory status with and without compatibility
    cycle(16'h37E8, 8'h00, 0, 0, 1, 1, 8'h81, "R3");
    cycle(16'h37E9, 8'h00, 0, 0, 1, 1, 8'h7E, "R3");
    cycle(16'h37E8, 8'h00, 0, 0, 1, 0, 8'h81, "R4");
    cycle(16'h37E9, 8'h00, 0, 0, 1, 0, 8'h7E, "R4");
    cycle(16'h37EA, 8'h00, 0, 0, 1, 1, 8'h7E, "R5");

    // R7: one write, count the low cycles of the pulse
    cycle(16'h00F8, 8'h5A, 0, 1, 0, 0, 8'h00, "R6");
    low_cnt = 0;
    for (int i = 0; i < SC + 5; i++) begin
      if (!prn_strobe_n) low_cnt++;
      idle(1);
    end
    check("R7 width", low_cnt, SC);

    // R6: write to 0xF9 ignored
    cycle(16'h00F9, 8'hFF, 0, 1, 0, 0, 8'h00, "R6");
    check("R6 F9 ignored", prn_data, 8'h5A);
    check("R6 no strobe", prn_strobe_n, 1);

    // R8: restart in mid-pulse
    cycle(16'h00F8, 8'h11, 0, 1, 0, 0, 8'h00, "R8");
    idle(SC / 2);
    cycle(16'h12F8, 8'h22, 0, 1, 0, 0, 8'h00, "R8");
    check("R8 new data", prn_data, 8'h22);
    low_cnt = 0;
    for (int i = 0; i < SC + 5; i++) begin
      if (!prn_strobe_n) low_cnt++;
      idle(1);
    end
    check("R8 width after restart", low_cnt, SC);

    // Random mix
    for (int i = 0; i < N_RAND; i++) begin
      logic [15:0] a;
      int k;
      k = $urandom_range(0, 6);
      case (k)
        0: a = 16'h00F8;
        1: a = 16'h00F9;
        2: a = 16'h37E8;
        3: a = 16'h37E9;
        4: a = {8'($urandom), 8'hF8};
        default: a = 16'($urandom);
      endcase
      cycle(a, 8'($urandom), 1'($urandom), ($urandom_range(0, 7) == 0),
            1'($urandom), 1'($urandom), 8'($urandom), "R2/R3/R4/R5");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule